// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout

This block is a supervisory timer for a small processor subsystem. Software configures it through one 8-bit control register on a simple register bus. The register holds a timeout code, an enable, a self-clearing restart command and a memory bank select bit. The bank select bit is passed straight out to the address logic of a neighbouring block. While the timer is enabled it counts pulses on a timebase tick input. If software fails to restart it within the selected window, it raises a reset request for exactly one clock.

The timeout is a power-of-two multiple of a base window. The parameter `BASE_TICKS` sets how many ticks make up the shortest window, which is nominally 16 ms. The 3-bit code multiplies that window by 2^code, so the longest window is nominally 2048 ms. Writing the restart bit as 1 produces a single clear pulse. That bit always reads back as 0.

Top module: `wdog_timer`

## Requirements
- R1: After reset, reading the control register returns 00h, the bank select output is 0 and the reset request is 0. A reset applied in mid-run restores this state.
- R2: The control register sits at bus address 96h with this layout: bits 7:5 timeout code, bit 2 bank select, bit 1 restart, bit 0 enable. Reads return 0 in bits 4, 3 and 1. Writing FFh reads back as E5h.
- R3: The bank select output equals the most recently written bit 2.
- R4: With the timer enabled and no restart, the reset request is raised after exactly `BASE_TICKS`·2^code tick pulses and not before. Cycles without a tick do not advance the count.
- R5: The reset request lasts one clock. The count then starts again from zero, so a further full window produces a second request.
- R6: Writing 1 to bit 1 clears the count, so a full window of ticks is needed after the write before the next request.
- R7: The restart command clears itself one clock after the write. Counting then continues, and bit 1 reads back as 0.
- R8: With the enable bit at 0, no reset request is raised, however many ticks arrive.
- R9: Clearing the enable bit clears the count. Re-enabling without a restart therefore still requires a full window.
- R10: Writes to any address other than 96h leave the register unchanged. Reads of any other address return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read access |
| tick_in | input | 1 | Timebase pulse, one clock wide per tick |
| bank_sel_o | output | 1 | Bank select bit from the control register |
| wdog_rst_req_o | output | 1 | One-clock reset request on timeout |

## Verification
The assertions assume that a timeout window is at least two ticks long, which holds when `BASE_TICKS` is 2 or more. Under that assumption the reset request can never be high in two consecutive clocks. They also assume that `tick_in` is a clean synchronous pulse. The bench sets `BASE_TICKS` to 4 and raises ticks only on alternate clocks. It never drives a tick in the same clock as a register write, so restart and enable changes always take effect between tick edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W      = 8;
  localparam int CODE_W     = 3;
  localparam int NUM_CODES  = 1 << CODE_W;
  localparam int CODE_LSB   = 5;
  localparam int BANK_BIT   = 2;
  localparam int RSTRT_BIT  = 1;
  localparam int EN_BIT     = 0;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              bank;
    logic              en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output wdog_ctrl_t        ctrl_o,
  output logic              restart_o,
  output logic              wr_hit_o
);
  wdog_ctrl_t ctrl_q, ctrl_d;
  logic       restart_q, restart_d;
  logic       addr_hit, wr_hit, rd_hit;

  assign addr_hit = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign wr_hit   = bus_sel &  bus_wr & addr_hit;
  assign rd_hit   = bus_sel & ~bus_wr & addr_hit;

  always_comb begin
    ctrl_d    = ctrl_q;
    restart_d = 1'b0;
    if (wr_hit) begin
      ctrl_d.code = bus_wdata[CODE_LSB +: CODE_W];
      ctrl_d.bank = bus_wdata[BANK_BIT];
      ctrl_d.en   = bus_wdata[EN_BIT];
      restart_d   = bus_wdata[RSTRT_BIT];
    end
  end

  // reset value 02h: the restart command is held for the first clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      restart_q <= 1'b1;
    end else begin
      ctrl_q    <= ctrl_d;
      restart_q <= restart_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      bus_rdata[CODE_LSB +: CODE_W] = ctrl_q.code;
      bus_rdata[BANK_BIT]           = ctrl_q.bank;
      bus_rdata[EN_BIT]             = ctrl_q.en;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign restart_o = restart_q;
  assign wr_hit_o  = wr_hit;
endmodule

// File: rtl/wdog_period.sv
module wdog_period
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int CNT_W      = 11
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  term
);
  logic [CNT_W-1:0] term_lut [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_term
    assign term_lut[g] = CNT_W'(BASE_TICKS * (1 << g) - 1);
  end

  assign term = term_lut[code];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!en || restart) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= term) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int         BASE_TICKS = 16,
  parameter logic [7:0] CTRL_ADDR  = 8'h96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_in,
  output logic       bank_sel_o,
  output logic       wdog_rst_req_o
);
  localparam int CNT_W = $clog2(BASE_TICKS << (NUM_CODES - 1));

  logic             rst_n_s;
  wdog_ctrl_t       ctrl_w;
  logic             restart_w;
  logic             wr_hit_w;
  logic [CNT_W-1:0] term_w;
  logic [CNT_W-1:0] cnt_w;

  wdog_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  wdog_regif #(.ADDR_W(8), .CTRL_ADDR(CTRL_ADDR)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_o    (ctrl_w),
    .restart_o (restart_w),
    .wr_hit_o  (wr_hit_w)
  );

  wdog_period #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_period (
    .code (ctrl_w.code),
    .term (term_w)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (ctrl_w.en),
    .restart (restart_w),
    .tick    (tick_in),
    .term    (term_w),
    .cnt_o   (cnt_w),
    .req_o   (wdog_rst_req_o)
  );

  assign bank_sel_o = ctrl_w.bank;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             restart,
  input logic             wr_hit,
  input logic             tick,
  input logic             req,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       rdata
);
  // R2
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & 8'h1A) == 8'h00);

  // R4
  req_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(tick));

  // R4
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !tick) |=> $stable(cnt));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  // R6
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !req));

  // R7
  restart_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !wr_hit) |=> !restart);

  // R8
  off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !req);

  // R9
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .en      (ctrl_w.en),
  .restart (restart_w),
  .wr_hit  (wr_hit_w),
  .tick    (tick_in),
  .req     (wdog_rst_req_o),
  .cnt     (cnt_w),
  .rdata   (bus_rdata)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int BASE = 4;
  localparam int NV   = 8;
  // {code[2:0], bank, expected ticks[15:0]}
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 1'b1, 16'd4},   {3'd1, 1'b0, 16'd8},
    {3'd2, 1'b1, 16'd16},  {3'd3, 1'b0, 16'd32},
    {3'd4, 1'b1, 16'd64},  {3'd5, 1'b0, 16'd128},
    {3'd6, 1'b1, 16'd256}, {3'd7, 1'b0, 16'd512}
  };

  logic       clk, rst_n, bus_sel, bus_wr, tick_in;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bank_sel_o, wdog_rst_req_o;
  int         n_tests, n_fail, req_cnt, req_double;
  logic       req_prev;

  wdog_timer #(.BASE_TICKS(BASE)) u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .bank_sel_o(bank_sel_o), .wdog_rst_req_o(wdog_rst_req_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (wdog_rst_req_o) req_cnt <= req_cnt + 1;
    if (wdog_rst_req_o && req_prev) req_double <= req_double + 1;
    req_prev <= wdog_rst_req_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 check(bus_rdata == exp, tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int c0;
    n_tests = 0; n_fail = 0; req_cnt = 0; req_double = 0; req_prev = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; tick_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h96, 8'h00, "R1 reg after reset");
    check(bank_sel_o == 1'b0, "R1 bank after reset", bank_sel_o, 0);
    check(wdog_rst_req_o == 1'b0, "R1 req after reset", wdog_rst_req_o, 0);

    // R2 layout and zero-read bits
    wr(8'h96, 8'hFF);
    rd(8'h96, 8'hE5, "R2 readback of FF");
    wr(8'h96, 8'h00);

    // R4 / R3 / R5 table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] code; logic bank; int per;
      code = VEC[v][19:17]; bank = VEC[v][16]; per = int'(VEC[v][15:0]);
      wr(8'h96, {code, 2'b00, bank, 2'b11});
      check(bank_sel_o == bank, "R3 bank output", bank_sel_o, bank);
      c0 = req_cnt;
      ticks(per - 1);
      check(req_cnt == c0, "R4 no early request", req_cnt - c0, 0);
      ticks(1);
      check(req_cnt == c0 + 1, "R4 request at window end", req_cnt - c0, 1);
      wr(8'h96, 8'h00);
    end
    check(req_double == 0, "R5 request one clock wide", req_double, 0);

    // R5 count restarts after a request
    wr(8'h96, 8'h03);
    c0 = req_cnt;
    ticks(4);
    ticks(3);
    check(req_cnt == c0 + 1, "R5 no request within second window", req_cnt - c0, 1);
    ticks(1);
    check(req_cnt == c0 + 2, "R5 second request", req_cnt - c0, 2);

    // R6 restart clears count
    wr(8'h96, 8'h23);
    c0 = req_cnt;
    ticks(7);
    wr(8'h96, 8'h23);
    ticks(7);
    check(req_cnt == c0, "R6 restart postpones request", req_cnt - c0, 0);
    ticks(1);
    check(req_cnt == c0 + 1, "R6 request after full window", req_cnt - c0, 1);

    // R7 restart bit reads as zero and self-clears
    rd(8'h96, 8'h21, "R7 restart bit reads 0");

    // R9 disabling clears the count
    c0 = req_cnt;
    ticks(7);
    wr(8'h96, 8'h20);
    wr(8'h96, 8'h21);
    ticks(7);
    check(req_cnt == c0, "R9 re-enable needs full window", req_cnt - c0, 0);
    ticks(1);
    check(req_cnt == c0 + 1, "R9 request after full window", req_cnt - c0, 1);

    // R8 disabled timer never requests
    wr(8'h96, 8'h00);
    c0 = req_cnt;
    ticks(20);
    check(req_cnt == c0, "R8 no request while disabled", req_cnt - c0, 0);

    // R10 address decode
    wr(8'h96, 8'h45);
    wr(8'h95, 8'hFF);
    wr(8'h97, 8'hFF);
    rd(8'h96, 8'h45, "R10 other address write ignored");
    rd(8'h95, 8'h00, "R10 other address reads zero");
    check(bank_sel_o == 1'b1, "R10 bank unchanged", bank_sel_o, 1);

    // R1 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h96, 8'h00, "R1 reg after mid-run reset");
    check(bank_sel_o == 1'b0, "R1 bank after mid-run reset", bank_sel_o, 0);

    summary();
  end
endmodule